// File: doc/BRIEF.md
# Protection information tuple checker

This block checks end-to-end protection information on a stream of logical blocks during a read or write transfer. A transfer is launched with a one-cycle start pulse that carries its settings: guard format (16-bit or 64-bit), protection type, three check enables, the expected application tag and its mask, the expected reference tag, the starting logical block address and the block count. The block then takes the blocks one byte per accepted cycle. Each block is `DATA_BYTES` of data followed by `META_BYTES` of metadata, and the protection tuple sits at the tail of the metadata.

For every block the block recomputes the guard CRC, captures the tuple, and judges the block in a dedicated cycle. Checks run in a fixed order. The first failing block ends the transfer with an error code, and any bytes still to come are then accepted and thrown away. A transfer that runs to its end without a failure reports success.

The controller has four states:
- `ST_IDLE`: waits for a start pulse.
- `ST_BODY`: takes block bytes.
- `ST_JUDGE`: a one-cycle verdict.
- `ST_DRAIN`: discards the bytes left after a failure.

The transitions are:
- *launch*: IDLE to BODY.
- *reject*: IDLE to DRAIN.
- *block_end*: BODY to JUDGE.
- *next_block*: JUDGE to BODY.
- *finish*: JUDGE to IDLE.
- *abort*: JUDGE to DRAIN.
- *drained*: DRAIN to IDLE.

Top module: `pi_tuple_checker`

## Requirements
- R1: A block is `DATA_BYTES` data bytes followed by `META_BYTES` metadata bytes. The tuple occupies the last 8 metadata bytes in 16-bit mode and the last 16 in 64-bit mode. All tuple fields are most-significant byte first. In 16-bit mode the tuple is guard (2 bytes), application tag (2), reference tag (4). In 64-bit mode it is guard (8), application tag (2), reference tag (6).
- R2: In 16-bit mode the guard is a CRC with polynomial 0x8BB7, seed 0, bits taken MSB first and no final inversion. It is computed over the data bytes followed by the metadata bytes that precede the tuple.
- R3: In 64-bit mode the guard is a bit-reflected CRC with polynomial 0x9A6C9329AC4BC9B5, seed all ones and a final inversion. It covers the same span: the data plus the metadata bytes that precede the tuple.
- R4: Under protection types 1 and 2 (`cfg_prot_type` 1 or 2), a block whose stored application tag is 0xFFFF passes without any check.
- R5: Under protection type 3, a block is skipped only when its application tag is 0xFFFF and its reference tag is all ones over the active width (32 bits in 16-bit mode, 48 bits in 64-bit mode). An application tag of 0xFFFF alone does not skip the block.
- R6: The guard is checked first, then the application tag, then the reference tag. The first failing block ends the transfer. Status codes are 0 for success, 1 for a guard error, 2 for an application tag error and 3 for a reference tag error.
- R7: The application tag matches when (stored AND mask) equals (expected AND mask).
- R8: The expected reference tag starts at `cfg_exp_ref` and steps by one after every block unless the type is 3. It is compared over the low 32 bits (16-bit mode) or the low 48 bits (64-bit mode) only.
- R9: Each of the guard, application tag and reference tag checks is performed only when its own enable bit is set.
- R10: In 64-bit mode, when block 0 of a transfer with start address 0 fails its guard and its data bytes are all zero, the block is treated as unchecked. The transfer then continues with the next block. The expected reference tag still steps after that block.
- R11: At start, a type-1 transfer with reference checking enabled is rejected with code 3 if the truncated start address differs from the truncated expected reference tag. The code is reported one cycle after the start pulse, and all of the transfer's bytes are then drained.
- R12: `stat_valid` is a one-cycle pulse, exactly one per transfer, and `stat_code` holds its value until the next report. After a failure the remaining bytes are accepted without changing the status. `busy` falls once the last byte of the transfer has been taken.
- R13: `in_ready` is low for exactly one cycle after the last byte of each judged block. No bytes are accepted during that verdict cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_start | input | 1 | One-cycle transfer launch, sampled while idle |
| cfg_wide_guard | input | 1 | 1 selects the 64-bit guard format |
| cfg_prot_type | input | 2 | Protection type: 1, 2 or 3 |
| cfg_chk_guard | input | 1 | Enable the guard check |
| cfg_chk_app | input | 1 | Enable the application tag check |
| cfg_chk_ref | input | 1 | Enable the reference tag check |
| cfg_app_tag | input | 16 | Expected application tag |
| cfg_app_mask | input | 16 | Application tag compare mask |
| cfg_exp_ref | input | 64 | Expected reference tag for the first block |
| cfg_start_lba | input | 64 | Starting logical block address |
| cfg_num_blocks | input | BLK_CNT_W | Blocks in the transfer (at least 1) |
| in_valid | input | 1 | Byte valid |
| in_byte | input | 8 | Stream byte |
| in_ready | output | 1 | Byte accepted when high together with `in_valid` |
| busy | output | 1 | A transfer is in progress |
| stat_valid | output | 1 | One-cycle status pulse |
| stat_code | output | 2 | Transfer status code |

## Verification
The assertions take three things for granted about the inputs: `xfer_start` arrives only while `busy` is low, `cfg_num_blocks` is at least one, and the settings stay valid for the start cycle. Under those conditions they require a single status pulse, a guard verdict ahead of the other checks, and a reference tag that holds under type 3 and otherwise steps by one. The bench respects these conditions. Every scenario waits for `busy` to fall before issuing the next start pulse, and it always requests between one and three blocks. It also offers bytes continuously, so every stall seen comes from the checker itself.

// File: rtl/pi_chk_pkg.sv
package pi_chk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_JUDGE = 2'd2,
        ST_DRAIN = 2'd3
    } chk_state_t;

    typedef enum logic [1:0] {
        STAT_PASS  = 2'd0,
        STAT_GUARD = 2'd1,
        STAT_APP   = 2'd2,
        STAT_REF   = 2'd3
    } chk_status_t;

    localparam int NARROW_TUPLE_BYTES = 8;
    localparam int WIDE_TUPLE_BYTES   = 16;

    localparam logic [15:0] CRC16_POLY   = 16'h8BB7;
    localparam logic [63:0] CRC64_POLY_R = 64'h9A6C9329AC4BC9B5;

    localparam logic [63:0] REF_MASK_NARROW = 64'h0000_0000_FFFF_FFFF;
    localparam logic [63:0] REF_MASK_WIDE   = 64'h0000_FFFF_FFFF_FFFF;

    // One byte through the 16-bit guard, most significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ b[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC16_POLY;
        end
        return r;
    endfunction

    // One byte through the reflected 64-bit guard, least significant bit first.
    function automatic logic [63:0] crc64_step(input logic [63:0] c, input logic [7:0] b);
        logic [63:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ b[i];
            r  = {1'b0, r[63:1]};
            if (fb) r = r ^ CRC64_POLY_R;
        end
        return r;
    endfunction

endpackage

// File: rtl/pi_guard_acc.sv
module pi_guard_acc
    import pi_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        crc_en,
    input  logic        zero_en,
    input  logic [7:0]  din,
    output logic [15:0] crc16_o,
    output logic [63:0] crc64_o,
    output logic        data_zero_o
);

    logic [15:0] c16_q;
    logic [63:0] c64_q;
    logic        zero_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c16_q  <= '0;
            c64_q  <= '1;
            zero_q <= 1'b1;
        end else if (clr) begin
            c16_q  <= '0;
            c64_q  <= '1;
            zero_q <= 1'b1;
        end else begin
            if (crc_en) begin
                c16_q <= crc16_step(c16_q, din);
                c64_q <= crc64_step(c64_q, din);
            end
            if (zero_en && (din != 8'h00)) zero_q <= 1'b0;
        end
    end

    assign crc16_o     = c16_q;
    assign crc64_o     = ~c64_q;
    assign data_zero_o = zero_q;

    // R2: a cleared accumulator restarts from the seed with the zero flag set
    p_clear_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc16_o == 16'h0000) && (crc64_o == 64'h0) && data_zero_o);

    // R10: any nonzero data byte withdraws the all-zero flag
    p_zero_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_en && !clr && (din != 8'h00)) |=> !data_zero_o);

    // The controller never clears and feeds in the same cycle
    p_clr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && (crc_en || zero_en)));

endmodule

// File: rtl/pi_tuple_shift.sv
module pi_tuple_shift
    import pi_chk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        shift_en,
    input  logic [7:0]  din,
    input  logic        wide,
    output logic [63:0] guard_o,
    output logic [15:0] app_o,
    output logic [47:0] ref_o
);

    localparam int WIN_W = 8 * WIDE_TUPLE_BYTES;

    logic [WIN_W-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        win_q <= '0;
        else if (shift_en) win_q <= {win_q[WIN_W-9:0], din};
    end

    // The newest bytes sit at the low end, so the tuple is always the tail.
    always_comb begin
        if (wide) begin
            guard_o = win_q[127:64];
            app_o   = win_q[63:48];
            ref_o   = win_q[47:0];
        end else begin
            guard_o = {48'h0, win_q[63:48]};
            app_o   = win_q[47:32];
            ref_o   = {16'h0, win_q[31:0]};
        end
    end

    // R1: each metadata byte lands in the lowest byte of the window
    p_shift_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (win_q[7:0] == $past(din)));

endmodule

// File: rtl/pi_tuple_checker.sv
module pi_tuple_checker
    import pi_chk_pkg::*;
#(
    parameter int DATA_BYTES = 32,
    parameter int META_BYTES = 16,
    parameter int BLK_CNT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer_start,
    input  logic                 cfg_wide_guard,
    input  logic [1:0]           cfg_prot_type,
    input  logic                 cfg_chk_guard,
    input  logic                 cfg_chk_app,
    input  logic                 cfg_chk_ref,
    input  logic [15:0]          cfg_app_tag,
    input  logic [15:0]          cfg_app_mask,
    input  logic [63:0]          cfg_exp_ref,
    input  logic [63:0]          cfg_start_lba,
    input  logic [BLK_CNT_W-1:0] cfg_num_blocks,
    input  logic                 in_valid,
    input  logic [7:0]           in_byte,
    output logic                 in_ready,
    output logic                 busy,
    output logic                 stat_valid,
    output logic [1:0]           stat_code
);

    // META_BYTES must be at least WIDE_TUPLE_BYTES.
    localparam int BLK_BYTES  = DATA_BYTES + META_BYTES;
    localparam int POS_W      = $clog2(BLK_BYTES);
    localparam int NARROW_LIM = BLK_BYTES - NARROW_TUPLE_BYTES;
    localparam int WIDE_LIM   = BLK_BYTES - WIDE_TUPLE_BYTES;

    chk_state_t  state_q, state_d;
    chk_status_t verdict, stat_code_q;
    logic        stat_valid_q;

    logic                 wide_q, cg_q, ca_q, cr_q;
    logic [1:0]           ptype_q;
    logic [15:0]          app_q, mask_q;
    logic [63:0]          eref_q, lba_q;
    logic [BLK_CNT_W-1:0] num_q, blk_q;
    logic [POS_W-1:0]     pos_q;

    logic        accept, last_byte, last_blk, reject, clr;
    logic        crc_en, zero_en, shift_en;
    logic [15:0] crc16;
    logic [63:0] crc64, t_guard, ref_mask, start_mask;
    logic [15:0] t_app;
    logic [47:0] t_ref;
    logic        data_zero;
    logic        escape, guard_bad, pardon, app_bad, ref_bad, ref_ones;

    assign in_ready  = (state_q == ST_BODY) || (state_q == ST_DRAIN);
    assign busy      = (state_q != ST_IDLE);
    assign accept    = in_valid && in_ready;
    assign last_byte = (pos_q == POS_W'(BLK_BYTES - 1));
    assign last_blk  = (blk_q == (num_q - BLK_CNT_W'(1)));

    assign start_mask = cfg_wide_guard ? REF_MASK_WIDE : REF_MASK_NARROW;
    assign reject = (cfg_prot_type == 2'd1) && cfg_chk_ref &&
                    (((cfg_start_lba ^ cfg_exp_ref) & start_mask) != 64'h0);

    // Feed routing inside a block
    always_comb begin
        crc_en   = 1'b0;
        zero_en  = 1'b0;
        shift_en = 1'b0;
        if ((state_q == ST_BODY) && accept) begin
            crc_en   = wide_q ? (int'(pos_q) < WIDE_LIM) : (int'(pos_q) < NARROW_LIM);
            zero_en  = int'(pos_q) < DATA_BYTES;
            shift_en = int'(pos_q) >= DATA_BYTES;
        end
    end

    assign clr = ((state_q == ST_IDLE) && xfer_start) || (state_q == ST_JUDGE);

    pi_guard_acc u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (clr),
        .crc_en      (crc_en),
        .zero_en     (zero_en),
        .din         (in_byte),
        .crc16_o     (crc16),
        .crc64_o     (crc64),
        .data_zero_o (data_zero)
    );

    pi_tuple_shift u_tuple (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (in_byte),
        .wide     (wide_q),
        .guard_o  (t_guard),
        .app_o    (t_app),
        .ref_o    (t_ref)
    );

    // Block verdict
    assign ref_mask  = wide_q ? REF_MASK_WIDE : REF_MASK_NARROW;
    assign ref_ones  = wide_q ? (&t_ref) : (&t_ref[31:0]);
    assign escape    = (t_app == 16'hFFFF) && ((ptype_q != 2'd3) || ref_ones);
    assign guard_bad = cg_q && (wide_q ? (t_guard != crc64) : (t_guard[15:0] != crc16));
    assign pardon    = wide_q && (blk_q == '0) && (lba_q == 64'h0) && data_zero;
    assign app_bad   = ca_q && (((t_app ^ app_q) & mask_q) != 16'h0);
    assign ref_bad   = cr_q && ((({16'h0, t_ref} ^ eref_q) & ref_mask) != 64'h0);

    always_comb begin
        verdict = STAT_PASS;
        if (escape || (guard_bad && pardon)) verdict = STAT_PASS;
        else if (guard_bad)                  verdict = STAT_GUARD;
        else if (app_bad)                    verdict = STAT_APP;
        else if (ref_bad)                    verdict = STAT_REF;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (xfer_start) state_d = reject ? ST_DRAIN : ST_BODY;
            ST_BODY:  if (accept && last_byte) state_d = ST_JUDGE;
            ST_JUDGE: begin
                if (last_blk)                 state_d = ST_IDLE;
                else if (verdict != STAT_PASS) state_d = ST_DRAIN;
                else                          state_d = ST_BODY;
            end
            ST_DRAIN: if (accept && last_byte && last_blk) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transfer context and position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wide_q  <= 1'b0;
            ptype_q <= 2'd1;
            cg_q    <= 1'b0;
            ca_q    <= 1'b0;
            cr_q    <= 1'b0;
            app_q   <= '0;
            mask_q  <= '0;
            eref_q  <= '0;
            lba_q   <= '0;
            num_q   <= BLK_CNT_W'(1);
            blk_q   <= '0;
            pos_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (xfer_start) begin
                    wide_q  <= cfg_wide_guard;
                    ptype_q <= cfg_prot_type;
                    cg_q    <= cfg_chk_guard;
                    ca_q    <= cfg_chk_app;
                    cr_q    <= cfg_chk_ref;
                    app_q   <= cfg_app_tag;
                    mask_q  <= cfg_app_mask;
                    eref_q  <= cfg_exp_ref;
                    lba_q   <= cfg_start_lba;
                    num_q   <= cfg_num_blocks;
                    blk_q   <= '0;
                    pos_q   <= '0;
                end
                ST_BODY: if (accept) pos_q <= last_byte ? '0 : pos_q + POS_W'(1);
                ST_JUDGE: begin
                    blk_q <= blk_q + BLK_CNT_W'(1);
                    if (ptype_q != 2'd3) eref_q <= eref_q + 64'd1;
                end
                ST_DRAIN: if (accept) begin
                    pos_q <= last_byte ? '0 : pos_q + POS_W'(1);
                    if (last_byte) blk_q <= blk_q + BLK_CNT_W'(1);
                end
            endcase
        end
    end

    // Status outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_valid_q <= 1'b0;
            stat_code_q  <= STAT_PASS;
        end else begin
            stat_valid_q <= 1'b0;
            if ((state_q == ST_IDLE) && xfer_start && reject) begin
                stat_valid_q <= 1'b1;
                stat_code_q  <= STAT_REF;
            end else if (state_q == ST_JUDGE) begin
                if (verdict != STAT_PASS) begin
                    stat_valid_q <= 1'b1;
                    stat_code_q  <= verdict;
                end else if (last_blk) begin
                    stat_valid_q <= 1'b1;
                    stat_code_q  <= STAT_PASS;
                end
            end
        end
    end

    assign stat_valid = stat_valid_q;
    assign stat_code  = stat_code_q;

    // R12: the status strobe lasts a single cycle
    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |=> !stat_valid);

    // R11: a rejected launch reports code 3 at once and moves to draining
    p_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && xfer_start && reject) |=>
            (stat_valid && (stat_code == 2'd3) && (state_q == ST_DRAIN)));

    // R6: a live guard mismatch wins over the other checks
    p_guard_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_JUDGE) && !escape && guard_bad && !pardon) |=>
            (stat_valid && (stat_code == 2'd1)));

    // R4: an escaped block never raises an error
    p_escape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_JUDGE) && escape) |=> !(stat_valid && (stat_code != 2'd0)));

    // R8: the expected tag steps after each block except under type 3
    p_ref_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_JUDGE) && (ptype_q != 2'd3)) |=> (eref_q == $past(eref_q) + 64'd1));
    p_ref_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_JUDGE) && (ptype_q == 2'd3)) |=> $stable(eref_q));

    // R13: the verdict cycle consumes no byte
    p_judge_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_JUDGE) |=> (pos_q == '0));

endmodule

// File: tb/pi_tuple_checker_tb_top.sv
`timescale 1ns/1ps
module pi_tuple_checker_tb_top;

    localparam int DB  = 32;
    localparam int MB  = 16;
    localparam int BLK = DB + MB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0;
    logic        cfg_wide_guard = 1'b0;
    logic [1:0]  cfg_prot_type = 2'd1;
    logic        cfg_chk_guard = 1'b0, cfg_chk_app = 1'b0, cfg_chk_ref = 1'b0;
    logic [15:0] cfg_app_tag = '0, cfg_app_mask = '0;
    logic [63:0] cfg_exp_ref = '0, cfg_start_lba = '0;
    logic [7:0]  cfg_num_blocks = 8'd1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready, busy, stat_valid;
    logic [1:0]  stat_code;

    int tests = 0, fails = 0;
    int pulses = 0, stalls = 0, cycles = 0;
    logic [1:0] last_code = '0;
    bit drained;
    logic [7:0] strm [0:255];

    always #2 clk = ~clk;

    pi_tuple_checker #(.DATA_BYTES(DB), .META_BYTES(MB), .BLK_CNT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start),
        .cfg_wide_guard(cfg_wide_guard), .cfg_prot_type(cfg_prot_type),
        .cfg_chk_guard(cfg_chk_guard), .cfg_chk_app(cfg_chk_app), .cfg_chk_ref(cfg_chk_ref),
        .cfg_app_tag(cfg_app_tag), .cfg_app_mask(cfg_app_mask),
        .cfg_exp_ref(cfg_exp_ref), .cfg_start_lba(cfg_start_lba),
        .cfg_num_blocks(cfg_num_blocks), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .busy(busy), .stat_valid(stat_valid), .stat_code(stat_code)
    );

    always @(negedge clk) begin
        cycles++;
        if (stat_valid) begin
            pulses++;
            last_code = stat_code;
        end
        if (busy && !in_ready) stalls++;
    end

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] b_crc16(input int base, input int n);
        logic [15:0] c = 16'h0;
        for (int i = 0; i < n; i++) begin
            c = c ^ {strm[base+i], 8'h00};
            for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h8BB7) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [63:0] b_crc64(input int base, input int n);
        logic [63:0] c = '1;
        for (int i = 0; i < n; i++) begin
            c = c ^ {56'h0, strm[base+i]};
            for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 64'h9A6C9329AC4BC9B5) : (c >> 1);
        end
        return ~c;
    endfunction

    // Build block k: data, metadata prefix, then a tuple with a correct guard xored by gflip
    task automatic mk_block(input int k, input bit w, input bit zero, input int seed,
                            input logic [15:0] app, input logic [63:0] rf,
                            input logic [63:0] gflip);
        int base = k * BLK;
        int t;
        logic [63:0] g;
        for (int i = 0; i < DB; i++)
            strm[base+i] = zero ? 8'h00 : 8'((seed + i * 29 + k * 53) & 255);
        for (int j = 0; j < MB; j++) strm[base+DB+j] = 8'(seed ^ (j * 17 + k));
        if (!w) begin
            t = base + DB + MB - 8;
            g = {48'h0, b_crc16(base, DB + MB - 8)} ^ gflip;
            strm[t] = g[15:8]; strm[t+1] = g[7:0];
            strm[t+2] = app[15:8]; strm[t+3] = app[7:0];
            for (int b = 0; b < 4; b++) strm[t+4+b] = rf[31-8*b -: 8];
        end else begin
            t = base + DB + MB - 16;
            g = b_crc64(base, DB + MB - 16) ^ gflip;
            for (int b = 0; b < 8; b++) strm[t+b] = g[63-8*b -: 8];
            strm[t+8] = app[15:8]; strm[t+9] = app[7:0];
            for (int b = 0; b < 6; b++) strm[t+10+b] = rf[47-8*b -: 8];
        end
    endtask

    task automatic run_xfer(input bit w, input logic [1:0] pt, input bit cg, input bit ca,
                            input bit cr, input logic [15:0] app, input logic [15:0] mask,
                            input logic [63:0] er, input logic [63:0] lba, input int nb);
        int total = nb * BLK;
        int idx = 0;
        int lim = 0;
        @(negedge clk);
        pulses = 0; stalls = 0;
        cfg_wide_guard = w; cfg_prot_type = pt; cfg_chk_guard = cg; cfg_chk_app = ca;
        cfg_chk_ref = cr; cfg_app_tag = app; cfg_app_mask = mask; cfg_exp_ref = er;
        cfg_start_lba = lba; cfg_num_blocks = 8'(nb);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        while (idx < total && lim < 5000) begin
            in_valid = 1'b1;
            in_byte = strm[idx];
            if (in_ready) idx++;
            @(negedge clk);
            lim++;
        end
        in_valid = 1'b0;
        lim = 0;
        while (busy && lim < 500) begin
            @(negedge clk);
            lim++;
        end
        repeat (2) @(negedge clk);
        drained = (idx == total) && !busy;
    endtask

    task automatic expect_code(input string req, input logic [1:0] exp);
        chk(pulses == 1, req, "status pulse count", 64'(pulses), 64'd1);
        chk(last_code == exp, req, "status code", 64'(last_code), 64'(exp));
        chk(drained, req, "all bytes taken and idle", 64'(drained), 64'd1);
    endtask

    task automatic t_reset;
        chk(!busy && !stat_valid && !in_ready && stat_code == 2'd0, "R12", "reset state",
            {60'h0, busy, stat_valid, in_ready, 1'b0}, 64'h0);
    endtask

    task automatic t_narrow_clean;
        for (int k = 0; k < 3; k++) mk_block(k, 0, 0, 7 + k, 16'h1234, 64'd5 + 64'(k), 64'h0);
        run_xfer(0, 2'd1, 1, 1, 1, 16'h1234, 16'hFFFF, 64'd5, 64'd5, 3);
        expect_code("R1", 2'd0);
        chk(stalls == 3, "R13", "verdict stalls", 64'(stalls), 64'd3);
    endtask

    task automatic t_wide_clean;
        mk_block(0, 1, 0, 3, 16'hBEEF, 64'h1234_5678_9ABC, 64'h0);
        mk_block(1, 1, 0, 4, 16'hBEEF, 64'h1234_5678_9ABD, 64'h0);
        run_xfer(1, 2'd2, 1, 1, 1, 16'hBEEF, 16'hFFFF, 64'hFFFF_1234_5678_9ABC, 64'h99, 2);
        expect_code("R3", 2'd0);
        chk(stalls == 2, "R13", "verdict stalls wide", 64'(stalls), 64'd2);
    endtask

    task automatic t_guard_err;
        for (int k = 0; k < 3; k++)
            mk_block(k, 0, 0, 11, 16'h1, 64'd20 + 64'(k), (k == 1) ? 64'h1 : 64'h0);
        run_xfer(0, 2'd1, 1, 1, 1, 16'h1, 16'hFFFF, 64'd20, 64'd20, 3);
        expect_code("R2", 2'd1);
        chk(stalls == 2, "R12", "drain after failure has no verdict", 64'(stalls), 64'd2);
    endtask

    task automatic t_priority;
        mk_block(0, 0, 0, 5, 16'h0F0F, 64'd9, 64'h4);
        run_xfer(0, 2'd2, 1, 1, 1, 16'h1111, 16'hFFFF, 64'd1, 64'd0, 1);
        expect_code("R6", 2'd1);
        mk_block(0, 0, 0, 5, 16'h0F0F, 64'd9, 64'h0);
        run_xfer(0, 2'd2, 1, 1, 1, 16'h1111, 16'hFFFF, 64'd1, 64'd0, 1);
        expect_code("R6", 2'd2);
        mk_block(0, 1, 0, 5, 16'h1111, 64'd9, 64'h0);
        run_xfer(1, 2'd2, 1, 1, 1, 16'h1111, 16'hFFFF, 64'd1, 64'd0, 1);
        expect_code("R6", 2'd3);
    endtask

    task automatic t_app_mask;
        mk_block(0, 0, 0, 8, 16'h12F4, 64'd3, 64'h0);
        run_xfer(0, 2'd2, 1, 1, 1, 16'h1234, 16'hFF0F, 64'd3, 64'd0, 1);
        expect_code("R7", 2'd0);
        run_xfer(0, 2'd2, 1, 1, 1, 16'h1234, 16'hFFFF, 64'd3, 64'd0, 1);
        expect_code("R7", 2'd2);
    endtask

    task automatic t_escape12;
        mk_block(0, 0, 0, 9, 16'hFFFF, 64'h77, 64'h55);
        run_xfer(0, 2'd2, 1, 1, 1, 16'h1234, 16'hFFFF, 64'd1, 64'd0, 1);
        expect_code("R4", 2'd0);
        mk_block(0, 1, 0, 9, 16'hFFFF, 64'h77, 64'h55);
        run_xfer(1, 2'd1, 1, 1, 1, 16'h1234, 16'hFFFF, 64'd6, 64'd6, 1);
        expect_code("R4", 2'd0);
    endtask

    task automatic t_type3;
        mk_block(0, 0, 0, 2, 16'hFFFF, 64'h1, 64'h8);
        run_xfer(0, 2'd3, 1, 1, 1, 16'h0, 16'hFFFF, 64'h1, 64'd0, 1);
        expect_code("R5", 2'd1);
        mk_block(0, 0, 0, 2, 16'hFFFF, 64'hFFFF_FFFF, 64'h8);
        run_xfer(0, 2'd3, 1, 1, 1, 16'h0, 16'hFFFF, 64'h1, 64'd0, 1);
        expect_code("R5", 2'd0);
        mk_block(0, 1, 0, 2, 16'hFFFF, 64'hFFFF_FFFF_FFFF, 64'h8);
        run_xfer(1, 2'd3, 1, 1, 1, 16'h0, 16'hFFFF, 64'h1, 64'd0, 1);
        expect_code("R5", 2'd0);
        mk_block(0, 1, 0, 2, 16'hFFFF, 64'h0000_FFFF_FFFF, 64'h8);
        run_xfer(1, 2'd3, 1, 1, 1, 16'h0, 16'hFFFF, 64'h1, 64'd0, 1);
        expect_code("R5", 2'd1);
    endtask

    task automatic t_type3_ref;
        mk_block(0, 0, 0, 1, 16'h2, 64'h40, 64'h0);
        mk_block(1, 0, 0, 2, 16'h2, 64'h40, 64'h0);
        run_xfer(0, 2'd3, 1, 1, 1, 16'h2, 16'hFFFF, 64'h40, 64'h99, 2);
        expect_code("R8", 2'd0);
        mk_block(1, 0, 0, 2, 16'h2, 64'h41, 64'h0);
        run_xfer(0, 2'd3, 1, 1, 1, 16'h2, 16'hFFFF, 64'h40, 64'h99, 2);
        expect_code("R8", 2'd3);
    endtask

    task automatic t_enables;
        mk_block(0, 0, 0, 4, 16'h5, 64'd2, 64'h10);
        run_xfer(0, 2'd1, 0, 1, 1, 16'h5, 16'hFFFF, 64'd2, 64'd2, 1);
        expect_code("R9", 2'd0);
        mk_block(0, 0, 0, 4, 16'h6, 64'd2, 64'h0);
        run_xfer(0, 2'd1, 1, 0, 1, 16'h5, 16'hFFFF, 64'd2, 64'd2, 1);
        expect_code("R9", 2'd0);
        mk_block(0, 1, 0, 4, 16'h5, 64'd30, 64'h0);
        run_xfer(1, 2'd2, 1, 1, 0, 16'h5, 16'hFFFF, 64'd2, 64'd2, 1);
        expect_code("R9", 2'd0);
    endtask

    task automatic t_zero_block;
        mk_block(0, 1, 1, 0, 16'h5555, 64'd0, 64'hDEAD);
        mk_block(1, 1, 0, 6, 16'h1234, 64'd1, 64'h0);
        run_xfer(1, 2'd1, 1, 1, 1, 16'h1234, 16'hFFFF, 64'd0, 64'd0, 2);
        expect_code("R10", 2'd0);
        mk_block(0, 1, 1, 0, 16'h1234, 64'd8, 64'hDEAD);
        run_xfer(1, 2'd1, 1, 1, 1, 16'h1234, 16'hFFFF, 64'd8, 64'd8, 1);
        expect_code("R10", 2'd1);
        mk_block(0, 1, 0, 6, 16'h1234, 64'd0, 64'hDEAD);
        run_xfer(1, 2'd1, 1, 1, 1, 16'h1234, 16'hFFFF, 64'd0, 64'd0, 1);
        expect_code("R10", 2'd1);
        mk_block(0, 1, 0, 6, 16'h1234, 64'd0, 64'h0);
        mk_block(1, 1, 1, 0, 16'h1234, 64'd1, 64'hDEAD);
        run_xfer(1, 2'd1, 1, 1, 1, 16'h1234, 16'hFFFF, 64'd0, 64'd0, 2);
        expect_code("R10", 2'd1);
        mk_block(0, 0, 1, 0, 16'h1234, 64'd0, 64'h3);
        run_xfer(0, 2'd1, 1, 1, 1, 16'h1234, 16'hFFFF, 64'd0, 64'd0, 1);
        expect_code("R10", 2'd1);
    endtask

    task automatic t_reject;
        mk_block(0, 0, 0, 3, 16'h1, 64'd11, 64'h0);
        mk_block(1, 0, 0, 3, 16'h1, 64'd12, 64'h0);
        run_xfer(0, 2'd1, 1, 1, 1, 16'h1, 16'hFFFF, 64'd11, 64'd10, 2);
        expect_code("R11", 2'd3);
        chk(stalls == 0, "R11", "reject drains with no verdict", 64'(stalls), 64'd0);
        mk_block(0, 0, 0, 3, 16'h1, 64'hA, 64'h0);
        run_xfer(0, 2'd1, 1, 1, 1, 16'h1, 16'hFFFF, 64'hABCD_0000_000A, 64'hA, 1);
        expect_code("R11", 2'd0);
        mk_block(0, 1, 0, 3, 16'h1, 64'h7, 64'h0);
        run_xfer(1, 2'd1, 1, 1, 1, 16'h1, 16'hFFFF, 64'h0002_0000_0000_0007,
                 64'h0001_0000_0000_0007, 1);
        expect_code("R11", 2'd0);
        run_xfer(1, 2'd1, 1, 1, 1, 16'h1, 16'hFFFF, 64'h7, 64'h0000_0001_0000_0007, 1);
        expect_code("R11", 2'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_narrow_clean();
        t_wide_clean();
        t_guard_err();
        t_priority();
        t_app_mask();
        t_escape12();
        t_type3();
        t_type3_ref();
        t_enables();
        t_zero_block();
        t_reject();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule